// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block walks an 8-bit processor core through the bus cycles of entering an interrupt or software break. When the core's control logic fires one of three start strobes (maskable interrupt, non-maskable interrupt or break), the sequencer captures the current program counter, stack pointer and status flags. It then issues exactly one bus access per clock: dummy reads, three pushes into the page-one stack, and a two-byte vector fetch. When it finishes, it hands back the new program counter, the decremented stack pointer and the interrupt-disable flag.

A break whose status push lands while a non-maskable interrupt is pending is taken over by that interrupt. The pending flag is acknowledged with a one-cycle pulse, so the latch outside behaves as if edge-triggered. The break bit already written stays set, and the vector comes from the non-maskable pair instead. A break that is not taken over raises a one-cycle deferral pulse, which tells the interrupt logic to hold off recognising a non-maskable interrupt for one more cycle. The bus is a plain cycle-by-cycle master with no back-pressure: read data must be valid in the same cycle the address is driven. `bus_req` marks the cycles that carry an access.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable or non-maskable entry lasts exactly seven bus cycles. The first two are reads at the captured PC, and the PC is not incremented.
- R2: The pushes go in this order: PC high byte, then PC low byte, then status. Each is a write to address 0x0100 OR SP, and SP drops by one after each push, wrapping from 0x00 to 0xFF with no indication.
- R3: The status byte is formed from `flags_in` (bit7 N, bit6 V, bit3 D, bit2 I, bit1 Z, bit0 C). The pushed byte keeps those six bits in place, forces bit 5 to 1, and carries the break bit in bit 4. Bits 5 and 4 of `flags_in` are ignored. Every write goes to page 0x01.
- R4: The pushed break bit is 0 for maskable and non-maskable entries and 1 for a break.
- R5: `idis_out` becomes 1 from the status-push cycle onward. The pushed I bit is the value captured at the start.
- R6: Maskable and break entries read the new PC low byte from 0xFFFE and then the high byte from 0xFFFF. Non-maskable entries use 0xFFFA and then 0xFFFB. `pc_out` then equals {high, low}.
- R7: A break lasts six bus cycles. It does one dummy read at the PC and then increments the PC, so the pushed return address is the captured PC plus one, with the carry reaching the high byte.
- R8: If `nmi_pending` is high during a break's status push, `nmi_ack` pulses in that cycle and the vector comes from 0xFFFA/0xFFFB. The pushed break bit stays 1.
- R9: A break that is not taken over pulses `nmi_defer` in its vector-low fetch cycle, which is the fifth cycle of its sequence.
- R10: `busy` is high from the cycle after an accepted strobe through the PC-high load cycle. `done` pulses for one cycle right after that load. Strobes and input changes while `busy` is high have no effect on the sequence or its results.
- R11: If several strobes arrive in the same cycle, the non-maskable interrupt wins over the break, and the break wins over the maskable interrupt.
- R12: `nmi_pending` has no effect on maskable or non-maskable entries: no `nmi_ack` pulse and no change of vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_irq | input | 1 | Maskable interrupt entry strobe |
| start_nmi | input | 1 | Non-maskable interrupt entry strobe |
| start_brk | input | 1 | Software break entry strobe |
| pc_in | input | 16 | Program counter to capture |
| sp_in | input | 8 | Stack pointer to capture |
| flags_in | input | 8 | Status flags (N,V,-,-,D,I,Z,C) |
| nmi_pending | input | 1 | Latched non-maskable request |
| bus_req | output | 1 | Bus access this cycle |
| bus_addr | output | 16 | Access address |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after PC high load |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 8 | Resulting stack pointer |
| idis_out | output | 1 | Resulting interrupt-disable flag |
| nmi_ack | output | 1 | Clears the pending latch (take-over) |
| nmi_defer | output | 1 | Delay non-maskable recognition one cycle |

## Verification
Two pairs of functions can meet in one cycle. The first is a break's status push and a pending non-maskable interrupt. The bench holds `nmi_pending` high through a break and expects the acknowledge in the push cycle, a pushed break bit of 1, the 0xFFFA/0xFFFB fetch, and no deferral pulse. The second is a running sequence and a fresh strobe. The bench fires further strobes and changes `pc_in` in the middle of a maskable entry, and it also fires all strobes at once from idle. It judges both cases by comparing the full recorded bus trace and the final PC, SP and flag against traces built from the requirements.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DUM1, ST_DUM2, ST_PSHH, ST_PSHL, ST_PSHP, ST_VECL, ST_VECH
  } step_t;
endpackage

// File: rtl/seq_status_pack.sv
module seq_status_pack #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] flags,
  input  logic          brk_bit,
  output logic [DW-1:0] packed_o
);
  // N,V at top, fixed one, break bit, then D,I,Z,C
  always_comb begin
    packed_o    = flags;
    packed_o[5] = 1'b1;
    packed_o[4] = brk_bit;
  end
endmodule

// File: rtl/seq_stack_ptr.sv
module seq_stack_ptr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] sp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp_q <= '0;
    else if (load) sp_q <= load_val;
    else if (dec)  sp_q <= sp_q - 1'b1;
  end

  // R2
  sp_wrap_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (sp_q == $past(sp_q) - 1'b1));
endmodule

// File: rtl/seq_vector_sel.sv
module seq_vector_sel #(
  parameter int             AW      = 16,
  parameter logic [AW-1:0]  IRQ_VEC = 16'hFFFE,
  parameter logic [AW-1:0]  NMI_VEC = 16'hFFFA
) (
  input  logic          use_nmi,
  input  logic          hi_sel,
  output logic [AW-1:0] vec_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);
  always_comb begin
    vec_addr = use_nmi ? NMI_VEC : IRQ_VEC;
    if (hi_sel) vec_addr = vec_addr + ONE;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [AW-1:0] IRQ_VEC    = 16'hFFFE,
  parameter logic [AW-1:0] NMI_VEC    = 16'hFFFA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_irq,
  input  logic          start_nmi,
  input  logic          start_brk,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] flags_in,
  input  logic          nmi_pending,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] sp_out,
  output logic          idis_out,
  output logic          nmi_ack,
  output logic          nmi_defer
);
  localparam int IDIS_BIT = 2;
  localparam logic [AW-1:0] PC_ONE = AW'(1);

  step_t         state_q, state_d;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] flags_q;
  logic          idis_q, use_nmi_q, brk_q, done_q;
  logic          accept, take_over, sp_dec;
  logic [DW-1:0] status_byte, sp_q;
  logic [AW-1:0] vec_addr;

  assign accept    = (state_q == ST_IDLE) && (start_irq || start_nmi || start_brk);
  assign take_over = (state_q == ST_PSHP) && brk_q && !use_nmi_q && nmi_pending;
  assign sp_dec    = (state_q == ST_PSHH) || (state_q == ST_PSHL) || (state_q == ST_PSHP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_DUM1;
      ST_DUM1: state_d = brk_q ? ST_PSHH : ST_DUM2;
      ST_DUM2: state_d = ST_PSHH;
      ST_PSHH: state_d = ST_PSHL;
      ST_PSHL: state_d = ST_PSHP;
      ST_PSHP: state_d = ST_VECL;
      ST_VECL: state_d = ST_VECH;
      ST_VECH: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pc_q      <= '0;
      flags_q   <= '0;
      idis_q    <= 1'b0;
      use_nmi_q <= 1'b0;
      brk_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_VECH);
      if (accept) begin
        pc_q      <= pc_in;
        flags_q   <= flags_in;
        idis_q    <= flags_in[IDIS_BIT];
        use_nmi_q <= start_nmi;
        brk_q     <= !start_nmi && start_brk;
      end
      if (state_q == ST_DUM1 && brk_q) pc_q <= pc_q + PC_ONE;
      if (state_q == ST_PSHP) begin
        idis_q <= 1'b1;
        if (take_over) use_nmi_q <= 1'b1;
      end
      if (state_q == ST_VECL) pc_q[DW-1:0]    <= bus_rdata;
      if (state_q == ST_VECH) pc_q[AW-1:DW]   <= bus_rdata;
    end
  end

  seq_status_pack #(.DW(DW)) u_pack (
    .flags(flags_q), .brk_bit(brk_q), .packed_o(status_byte)
  );

  seq_stack_ptr #(.W(DW)) u_sp (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(sp_in),
    .dec(sp_dec), .sp_q(sp_q)
  );

  seq_vector_sel #(.AW(AW), .IRQ_VEC(IRQ_VEC), .NMI_VEC(NMI_VEC)) u_vec (
    .use_nmi(use_nmi_q), .hi_sel(state_q == ST_VECH), .vec_addr(vec_addr)
  );

  always_comb begin
    bus_req   = (state_q != ST_IDLE);
    bus_we    = sp_dec;
    bus_addr  = pc_q;
    bus_wdata = '0;
    unique case (state_q)
      ST_PSHH: begin bus_addr = {STACK_PAGE, sp_q}; bus_wdata = pc_q[AW-1:DW]; end
      ST_PSHL: begin bus_addr = {STACK_PAGE, sp_q}; bus_wdata = pc_q[DW-1:0];  end
      ST_PSHP: begin bus_addr = {STACK_PAGE, sp_q}; bus_wdata = status_byte;   end
      ST_VECL, ST_VECH: bus_addr = vec_addr;
      default: ;
    endcase
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign pc_out    = pc_q;
  assign sp_out    = sp_q;
  assign idis_out  = idis_q;
  assign nmi_ack   = take_over;
  assign nmi_defer = (state_q == ST_VECL) && brk_q && !use_nmi_q;

  // R3
  stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_addr[AW-1:DW] == STACK_PAGE));
  // R5
  idis_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PSHP) |=> idis_out);
  // R8
  ack_in_brk_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |-> (bus_we && bus_wdata[4]));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state_q != ST_VECH) |=> busy);
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_irq = 0, start_nmi = 0, start_brk = 0, nmi_pending = 0;
  logic [15:0] pc_in = '0;
  logic [7:0]  sp_in = '0, flags_in = '0, bus_rdata;
  logic bus_req, bus_we, busy, done, idis_out, nmi_ack, nmi_defer;
  logic [15:0] bus_addr, pc_out;
  logic [7:0]  bus_wdata, sp_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_entry_seq uut (.*);

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    case (a)
      16'hFFFE: return 8'h34;
      16'hFFFF: return 8'h12;
      16'hFFFA: return 8'h78;
      16'hFFFB: return 8'h56;
      default:  return a[7:0] ^ 8'hA5;
    endcase
  endfunction
  assign bus_rdata = mem_rd(bus_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 irq, 1 nmi, 2 brk, 3 all strobes, 4 brk+irq
  task automatic run_entry(input int kind, input logic [15:0] pc, input logic [7:0] sp,
                           input logic [7:0] fl, input bit pend, input bit intrude, input string tag);
    logic [24:0] tr [0:15];
    logic [24:0] ex [0:15];
    int n = 0, acks = 0, dfx = -1, en = 0;
    bit is_brk = (kind == 2 || kind == 4);
    bit nmi_vec = (kind == 1 || kind == 3 || (is_brk && pend));
    logic [15:0] rpc = is_brk ? pc + 16'd1 : pc;
    logic [7:0]  s = sp;
    logic [15:0] v = nmi_vec ? 16'hFFFA : 16'hFFFE;
    @(negedge clk);
    pc_in = pc; sp_in = sp; flags_in = fl; nmi_pending = pend;
    start_irq = (kind == 0 || kind == 3 || kind == 4);
    start_nmi = (kind == 1 || kind == 3);
    start_brk = (kind == 2 || kind == 3 || kind == 4);
    @(negedge clk);
    start_irq = 0; start_nmi = 0; start_brk = 0;
    while (busy && n < 16) begin
      tr[n] = {bus_addr, bus_we, bus_we ? bus_wdata : 8'h00};
      if (nmi_ack) acks++;
      if (nmi_defer) dfx = n;
      if (intrude && n == 2) begin
        start_nmi = 1; start_brk = 1; pc_in = 16'hDEAD; sp_in = 8'h11;
      end
      n++;
      @(negedge clk);
      start_irq = 0; start_nmi = 0; start_brk = 0;
    end
    nmi_pending = 0;
    // expected trace
    ex[en++] = {pc, 1'b0, 8'h00};
    if (!is_brk) ex[en++] = {pc, 1'b0, 8'h00};
    ex[en++] = {8'h01, s, 1'b1, rpc[15:8]}; s = s - 8'd1;
    ex[en++] = {8'h01, s, 1'b1, rpc[7:0]};  s = s - 8'd1;
    ex[en++] = {8'h01, s, 1'b1, fl[7:6], 1'b1, is_brk, fl[3:0]}; s = s - 8'd1;
    ex[en++] = {v, 1'b0, 8'h00};
    ex[en++] = {v + 16'd1, 1'b0, 8'h00};
    check({tag, " cycle count (R1/R7)"}, n, en);
    for (int i = 0; i < en && i < n; i++)
      check($sformatf("%s access %0d (R2 R3 R4 R6)", tag, i), {7'd0, tr[i]}, {7'd0, ex[i]});
    check({tag, " R10 done pulse"}, {done, busy}, 2'b10);
    check({tag, " R6 pc_out"}, pc_out, nmi_vec ? 16'h5678 : 16'h1234);
    check({tag, " R2 sp_out"}, sp_out, s);
    check({tag, " R5 idis_out"}, idis_out, 1'b1);
    check({tag, " R8/R12 ack count"}, acks, (is_brk && pend) ? 1 : 0);
    check({tag, " R9 defer cycle"}, dfx, (is_brk && !pend) ? 4 : -1);
    @(negedge clk);
    check({tag, " R10 done one cycle"}, done, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset busy/done/req", {busy, done, bus_req}, 3'b000);
    check("R2 reset pc/sp", {pc_out, sp_out}, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R12: maskable entry with a pending NMI ignored
    run_entry(0, 16'hC0F3, 8'hFD, 8'hC3, 1'b1, 1'b0, "irq");
    // R2 R3: SP wrap, flag bits 5/4 ignored
    run_entry(1, 16'h8000, 8'h01, 8'h3C, 1'b0, 1'b0, "nmi");
    // R7 R9: break, increment carries into high byte
    run_entry(2, 16'hE0FF, 8'h80, 8'h00, 1'b0, 1'b0, "brk");
    // R8: break taken over by pending NMI
    run_entry(2, 16'h1234, 8'h40, 8'hFF, 1'b1, 1'b0, "brk_takeover");
    // R10: strobes and inputs during busy ignored
    run_entry(0, 16'h2000, 8'hF0, 8'h81, 1'b0, 1'b1, "irq_intrude");
    // R11: priority
    run_entry(3, 16'h4444, 8'h22, 8'h40, 1'b0, 1'b0, "all_strobes");
    run_entry(4, 16'h5555, 8'h33, 8'h02, 1'b0, 1'b0, "brk_over_irq");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule